// File: doc/BRIEF.md
# Cascadable Dual Match Timer

This block holds two 8-bit up-counters. Each counter advances on a one-cycle count strobe and has its own compare value, run bit, interrupt flag and interrupt enable. When a counter reaches its compare value, that timer's flag goes high and the counter goes back to zero. This gives a periodic interval. Both timers drive one shared interrupt line, so software reads the two flags to find out which timer raised it.

A cascade bit joins the two counters into one 16-bit counter. In cascade mode the first timer's strobe, run bit, flag and enable control the pair. The second timer's fields give the high byte of the count and of the compare value. Each compare value is held in a latch that is separate from the register software writes. The latch loads at start and at every match, so a new period value written while the counter runs takes effect from the next period.

Top module: `dual_match_timer`

## Requirements
- R1: After reset every register reads 0x00 and `irq` is low.
- R2: Register map, selected by `reg_addr`:
  - 0 is control A: bit0 run, bit1 interrupt enable, bit2 flag, bit3 cascade.
  - 1 is control B: bit0 run, bit1 interrupt enable, bit2 flag.
  - 2 is compare data A (low byte in cascade mode).
  - 3 is compare data B (high byte in cascade mode).
  - Reads are combinational. Control B bits 7:3 and control A bits 7:4 read as 0.
- R3: Writing run from 0 to 1 clears that counter and loads its compare latch from the data register. A running timer then flags on the (N+1)th strobe, where N is the latched compare value.
- R4: The flag is set on a match whether or not the interrupt enable is set. With the enable at 0, `irq` stays low.
- R5: The strobe that matches also reloads the counter to 0, so the flag sets again every N+1 strobes.
- R6: Writing 0 to a flag bit clears it. Writing 1 to a flag bit leaves it unchanged.
- R7: `irq` is high exactly when (flag A and enable A) or, outside cascade mode, (flag B and enable B). If the flag is already set, raising the enable drives `irq` high right after that write.
- R8: A write that clears run in the same cycle as a matching strobe stops the counter, and the flag is not set.
- R9: A hardware match and a software flag clear in the same cycle leave the flag at 1.
- R10: In cascade mode the 16-bit counter advances on `tick_a` and matches {data B, data A}. Flag B is never set by hardware, and `tick_b` has no effect.
- R11: A data write while the timer runs does not change the current period. The new value applies after the next match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| tick_a | input | 1 | Count strobe for timer A (and for the cascaded pair) |
| tick_b | input | 1 | Count strobe for timer B |
| irq | output | 1 | Shared interrupt request |

## Verification
A counter or compare latch holding a wrong value shows up only as a flag that rises on the wrong strobe. The bench therefore checks the flag on the strobe just before the expected match and again on the match strobe. A bad latch load shows up one full period later, so the period-change test waits through two matches. A wrong flag or enable state shows at `irq` and `reg_rdata` in the cycle right after the write or strobe that caused it.

// File: rtl/dual_match_timer.sv
module dual_match_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       tick_a,
  input  logic       tick_b,
  output logic       irq
);
  logic       run_a, ien_a, flg_a, casc;
  logic       run_b, ien_b, flg_b;
  logic [7:0] cnt_a, cnt_b, lat_a, lat_b, dat_a, dat_b;

  logic wr_ca, wr_cb, start_a, start_b, stop_a, stop_b, go_a, go_b;
  logic hit_a, hit_b;

  assign wr_ca   = reg_we && reg_addr == 2'd0;
  assign wr_cb   = reg_we && reg_addr == 2'd1;
  assign start_a = wr_ca && reg_wdata[0] && !run_a;
  assign start_b = wr_cb && reg_wdata[0] && !run_b;
  assign stop_a  = wr_ca && !reg_wdata[0];
  assign stop_b  = wr_cb && !reg_wdata[0];
  assign go_a    = tick_a && run_a && !stop_a;
  assign go_b    = !casc && tick_b && run_b && !stop_b;
  assign hit_a   = go_a && (casc ? {cnt_b, cnt_a} == {lat_b, lat_a} : cnt_a == lat_a);
  assign hit_b   = go_b && cnt_b == lat_b;

  assign irq = (flg_a && ien_a) || (!casc && flg_b && ien_b);

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {4'b0, casc, flg_a, ien_a, run_a};
      2'd1:    reg_rdata = {5'b0, flg_b, ien_b, run_b};
      2'd2:    reg_rdata = dat_a;
      default: reg_rdata = dat_b;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {run_a, ien_a, casc, run_b, ien_b} <= '0;
      dat_a <= '0;
      dat_b <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        2'd0: {casc, ien_a, run_a} <= {reg_wdata[3], reg_wdata[1:0]};
        2'd1: {ien_b, run_b} <= reg_wdata[1:0];
        2'd2: dat_a <= reg_wdata;
        default: dat_b <= reg_wdata;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flg_a <= 1'b0;
      flg_b <= 1'b0;
    end else begin
      flg_a <= hit_a || (flg_a && !(wr_ca && !reg_wdata[2]));
      flg_b <= hit_b || (flg_b && !(wr_cb && !reg_wdata[2]));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_a <= '0; cnt_b <= '0; lat_a <= '0; lat_b <= '0;
    end else if (casc) begin
      if (start_a || hit_a) begin
        {cnt_b, cnt_a} <= '0;
        {lat_b, lat_a} <= {dat_b, dat_a};
      end else if (go_a) begin
        {cnt_b, cnt_a} <= {cnt_b, cnt_a} + 16'd1;
      end
    end else begin
      if (start_a || hit_a) begin
        cnt_a <= '0;
        lat_a <= dat_a;
      end else if (go_a) begin
        cnt_a <= cnt_a + 8'd1;
      end
      if (start_b || hit_b) begin
        cnt_b <= '0;
        lat_b <= dat_b;
      end else if (go_b) begin
        cnt_b <= cnt_b + 8'd1;
      end
    end
  end

  // R4: a match always raises the flag on the next edge
  a_r4_match_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    hit_a |=> flg_a);
  // R6: writing 1 to a clear flag does not set it
  a_r6_write_one_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ca && reg_wdata[2] && !flg_a && !hit_a) |=> !flg_a);
  // R7: enabled flag A drives irq
  a_r7_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_a && ien_a) |-> irq);
  // R8: stop write with flag clear leaves flag clear
  a_r8_stop_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ca && !reg_wdata[0] && !flg_a) |=> !flg_a);
  // R10: in cascade mode hardware never raises flag B
  a_r10_no_flag_b: assert property (@(posedge clk) disable iff (!rst_n)
    (casc && !flg_b) |=> !flg_b);
endmodule

// File: tb/dual_match_timer_bench.sv
`timescale 1ns/1ps
module dual_match_timer_bench;
  logic clk = 0, rst_n = 0, reg_we = 0, tick_a = 0, tick_b = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic irq;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  dual_match_timer u_dual_match_timer (.*);

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk) begin reg_we = 1; reg_addr = a; reg_wdata = d; end
    @(negedge clk) reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk) reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic ticks_a(input int n);
    @(negedge clk) tick_a = 1;
    repeat (n) @(posedge clk);
    @(negedge clk) tick_a = 0;
  endtask

  task automatic ticks_b(input int n);
    @(negedge clk) tick_b = 1;
    repeat (n) @(posedge clk);
    @(negedge clk) tick_b = 0;
  endtask

  task automatic flag_a(input string req, input logic exp);
    logic [7:0] d;
    rd(0, d);
    check(req, d[2], exp);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    for (int i = 0; i < 4; i++) begin
      rd(i[1:0], d);
      check("R1 reg", d, 0);
    end
    check("R1 irq", irq, 0);
  endtask

  task automatic t_interval();
    do_reset();
    wr(2, 3); wr(0, 8'h01);
    ticks_a(3); flag_a("R3 before match", 0);
    ticks_a(1); flag_a("R3 match", 1);
    check("R4 irq off", irq, 0);
    wr(0, 8'h01);
    ticks_a(3); flag_a("R5 reload before", 0);
    ticks_a(1); flag_a("R5 reload match", 1);
  endtask

  task automatic t_enable_flag();
    logic [7:0] d;
    check("R7 irq before enable", irq, 0);
    wr(0, 8'h07);
    #1 check("R7 immediate irq", irq, 1);
    flag_a("R6 write one keeps", 1);
    wr(0, 8'h03);
    flag_a("R6 write zero clears", 0);
    check("R7 irq drops", irq, 0);
    wr(0, 8'h07);
    flag_a("R6 write one inert", 0);
    rd(2, d);
    check("R2 data A readback", d, 3);
  endtask

  task automatic t_timer_b();
    logic [7:0] d;
    do_reset();
    wr(3, 1); wr(1, 8'h03);
    ticks_b(1); check("R7 B no irq yet", irq, 0);
    ticks_b(1);
    rd(1, d);
    check("R2 ctrl B", d, 8'h07);
    check("R7 shared irq from B", irq, 1);
    flag_a("R7 A flag untouched", 0);
  endtask

  task automatic t_stop_at_match();
    do_reset();
    wr(2, 2); wr(0, 8'h01);
    ticks_a(2);
    @(negedge clk) begin tick_a = 1; reg_we = 1; reg_addr = 0; reg_wdata = 8'h00; end
    @(negedge clk) begin tick_a = 0; reg_we = 0; end
    flag_a("R8 stop at match", 0);
  endtask

  task automatic t_set_beats_clear();
    do_reset();
    wr(2, 1); wr(0, 8'h01);
    ticks_a(1);
    @(negedge clk) begin tick_a = 1; reg_we = 1; reg_addr = 0; reg_wdata = 8'h01; end
    @(negedge clk) begin tick_a = 0; reg_we = 0; end
    flag_a("R9 set beats clear", 1);
  endtask

  task automatic t_cascade();
    logic [7:0] d;
    do_reset();
    wr(2, 2); wr(3, 1); wr(0, 8'h08); wr(0, 8'h09);
    ticks_b(5);
    ticks_a(258); flag_a("R10 before 16-bit match", 0);
    ticks_a(1); flag_a("R10 16-bit match", 1);
    rd(1, d);
    check("R10 flag B not set", d[2], 0);
    check("R10 irq disabled", irq, 0);
  endtask

  task automatic t_latch();
    do_reset();
    wr(2, 5); wr(0, 8'h01);
    ticks_a(2); wr(2, 1);
    ticks_a(3); flag_a("R11 old period holds", 0);
    ticks_a(1); flag_a("R11 old period match", 1);
    wr(0, 8'h01);
    ticks_a(1); flag_a("R11 new period before", 0);
    ticks_a(1); flag_a("R11 new period match", 1);
  endtask

  initial begin
    t_reset();
    t_interval();
    t_enable_flag();
    t_timer_b();
    t_stop_at_match();
    t_set_beats_clear();
    t_cascade();
    t_latch();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule